// File: doc/BRIEF.md
# If-Then Conditional Execution Sequencer

This block sits beside an instruction decoder and follows a conditional block opened by a 16-bit If-Then instruction. When such an instruction is decoded, the sequencer takes a base condition code and a four-bit pattern mask. Together they describe one to four following instructions, called slots. After the first slot, each slot is marked either "then" (base condition) or "else" (base condition with its lowest bit flipped).

For every later instruction issued while a block is open, the block reports the condition that governs that instruction. It also reports whether the instruction may execute, judged from the live N, Z, C and V flags. The whole block state is presented as a 9-bit word, so an exception entry can save it in the middle of a block and the return path can write it back to resume. The block flags as a fault any If-Then instruction that arrives inside an open block, any empty pattern, and any write to the program counter from a slot that is not the final one.

Top module: `it_seq`

## Requirements
- R1: After reset no block is open: `active`=0, `slot_cond`=14 (always), `exec_ok`=1, `fault`=0, `save_state`=0.
- R2: `it_valid` with a nonzero `it_mask` while idle opens a block on the next edge, and the first slot's `slot_cond` equals `it_cond`.
- R3: The lowest set bit of `it_mask` gives the length: bit 3 gives 1 slot, bit 2 gives 2, bit 1 gives 3 and bit 0 gives 4. The mask bits above that terminator, read from bit 3 downward, mark slots 2, 3 and 4, with 1 meaning else.
- R4: An else slot reports `slot_cond` equal to the base condition with bit 0 inverted. A then slot reports the base condition unchanged.
- R5: `exec_ok` is combinational from `slot_cond` and `nzcv` ({N,Z,C,V} in bits 3..0). The codes are 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !(C&!Z), 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 its inverse, and 14 and 15 always true.
- R6: Each `issue` pulse while a block is open (and `it_valid` low) moves to the next slot. The block closes after its last slot, and `issue` while idle changes nothing.
- R7: `save_state` is {base[3:0], q[4:0]}. q[4] is the current slot's else bit, the next bits down hold the else bits of the remaining slots, then a single 1 terminator, then zeros. The word is all zeros when idle.
- R8: `restore` loads `restore_state` on the next edge and takes priority over every other input. A word whose bits 3..0 are zero restores to idle (all zeros).
- R9: `it_valid` while a block is open raises `fault` in the same cycle and leaves the state unchanged.
- R10: `it_valid` with `it_mask`=0 raises `fault` in the same cycle and opens no block.
- R11: `issue` with `pc_write` from an open block's non-final slot raises `fault` in the same cycle and closes the block. From the final slot it raises no fault and the block ends normally.
- R12: `it_valid` takes precedence over `issue` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| it_valid | input | 1 | An If-Then instruction is decoded this cycle |
| it_cond | input | 4 | Base condition code of that instruction |
| it_mask | input | 4 | Slot pattern and length |
| issue | input | 1 | A non-If-Then instruction is issued this cycle |
| pc_write | input | 1 | The issued instruction writes the program counter |
| nzcv | input | 4 | Current flags {N,Z,C,V} |
| restore | input | 1 | Write `restore_state` into the block |
| restore_state | input | 9 | Saved state word being restored |
| active | output | 1 | A conditional block is open |
| slot_cond | output | 4 | Condition governing the current instruction |
| exec_ok | output | 1 | Current instruction passes its condition |
| fault | output | 1 | Illegal sequence in this cycle |
| save_state | output | 9 | State word for saving on exception |

## Verification
`fault` and `exec_ok` are combinational, so they are due in the same cycle as the inputs that cause them. State changes from loads, issues, aborts and restores show up on `active`, `slot_cond` and `save_state` one edge later. The bench drives inputs on the falling edge and compares all outputs against its model 1 ns later, still inside that cycle. It then advances the model at the following rising edge, so every comparison sees the combinational result of the current inputs over the state the previous edge left.

// File: rtl/it_seq.sv
`timescale 1ns/1ps
module it_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       it_valid,
  input  logic [3:0] it_cond,
  input  logic [3:0] it_mask,
  input  logic       issue,
  input  logic       pc_write,
  input  logic [3:0] nzcv,
  input  logic       restore,
  input  logic [8:0] restore_state,
  output logic       active,
  output logic [3:0] slot_cond,
  output logic       exec_ok,
  output logic       fault,
  output logic [8:0] save_state
);

  logic [3:0] base;
  logic [4:0] q;
  logic       last, load_ok, bad_it, bad_br;

  function automatic logic cond_pass(input logic [3:0] cc, input logic [3:0] f);
    logic n, z, c, v, r;
    {n, z, c, v} = f;
    case (cc[3:1])
      3'd0: r = z;
      3'd1: r = c;
      3'd2: r = n;
      3'd3: r = v;
      3'd4: r = c & ~z;
      3'd5: r = (n == v);
      3'd6: r = ~z & (n == v);
      default: r = 1'b1;
    endcase
    return (cc[3:1] != 3'd7 && cc[0]) ? ~r : r;
  endfunction

  assign active     = |q[3:0];
  assign last       = (q[2:0] == 3'd0);
  assign slot_cond  = active ? {base[3:1], base[0] ^ q[4]} : 4'hE;
  assign exec_ok    = cond_pass(slot_cond, nzcv);
  assign load_ok    = it_valid & ~active & (|it_mask);
  assign bad_it     = it_valid & (active | ~(|it_mask));
  assign bad_br     = ~it_valid & issue & pc_write & active & ~last;
  assign fault      = bad_it | bad_br;
  assign save_state = {base, q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base <= '0;
      q    <= '0;
    end else if (restore) begin
      if (|restore_state[3:0]) begin
        base <= restore_state[8:5];
        q    <= restore_state[4:0];
      end else begin
        base <= '0;
        q    <= '0;
      end
    end else if (load_ok) begin
      base <= it_cond;
      q    <= {1'b0, it_mask};
    end else if (it_valid) begin
      base <= base;
      q    <= q;
    end else if (bad_br || (issue && active && last)) begin
      base <= '0;
      q    <= '0;
    end else if (issue && active) begin
      q    <= {q[3:0], 1'b0};
    end
  end

  a_r2_open_block: assert property (@(posedge clk) disable iff (!rst_n)
    (it_valid && !active && it_mask != 4'd0 && !restore) |=> (active && slot_cond == $past(it_cond)));

  a_r6_close_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !it_valid && !restore && active && save_state[2:0] == 3'd0) |=> !active);

  a_r9_nested_it_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (it_valid && active && !restore) |=> $stable(save_state));

  a_r11_branch_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && pc_write && !it_valid && !restore && active && save_state[2:0] != 3'd0) |-> fault ##1 !active);

  a_r8_restore_word: assert property (@(posedge clk) disable iff (!rst_n)
    (restore && restore_state[3:0] != 4'd0) |=> save_state == $past(restore_state));

  a_r1_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (slot_cond == 4'hE && exec_ok));

endmodule

// File: tb/sim_it_seq.sv
`timescale 1ns/1ps
module sim_it_seq;
  logic clk = 0, rst_n = 0;
  logic it_valid = 0, issue = 0, pc_write = 0, restore = 0;
  logic [3:0] it_cond = 0, it_mask = 0, nzcv = 0;
  logic [8:0] restore_state = 0;
  logic active, exec_ok, fault;
  logic [3:0] slot_cond;
  logic [8:0] save_state;

  int total = 0, bad = 0;
  logic [3:0] m_base = 0;
  bit m_inv[$];

  always #2 clk = ~clk;

  it_seq u0 (.clk(clk), .rst_n(rst_n), .it_valid(it_valid), .it_cond(it_cond),
    .it_mask(it_mask), .issue(issue), .pc_write(pc_write), .nzcv(nzcv),
    .restore(restore), .restore_state(restore_state), .active(active),
    .slot_cond(slot_cond), .exec_ok(exec_ok), .fault(fault), .save_state(save_state));

  function automatic bit ref_pass(input logic [3:0] cc, input logic [3:0] f);
    bit n = f[3], z = f[2], c = f[1], v = f[0];
    case (cc)
      0: return z;            1: return !z;
      2: return c;            3: return !c;
      4: return n;            5: return !n;
      6: return v;            7: return !v;
      8: return c && !z;      9: return !c || z;
      10: return n == v;      11: return n != v;
      12: return !z && n == v; 13: return z || n != v;
      default: return 1;
    endcase
  endfunction

  function automatic logic [8:0] ref_word();
    logic [4:0] qq = 0;
    int idx = 4;
    if (m_inv.size() == 0) return 9'd0;
    foreach (m_inv[k]) begin qq[idx] = m_inv[k]; idx--; end
    qq[idx] = 1'b1;
    return {m_base, qq};
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit l, input logic [3:0] lc, input logic [3:0] lm,
                      input bit is, input bit br, input logic [3:0] f,
                      input bit rs, input logic [8:0] rw, input string tag);
    bit e_act, e_fault, e_ok;
    logic [3:0] e_cond;
    @(negedge clk);
    it_valid = l; it_cond = lc; it_mask = lm; issue = is; pc_write = br;
    nzcv = f; restore = rs; restore_state = rw;
    #1;
    e_act = m_inv.size() != 0;
    e_cond = e_act ? {m_base[3:1], m_base[0] ^ m_inv[0]} : 4'd14;
    e_ok = ref_pass(e_cond, f);
    e_fault = (l && (e_act || lm == 0)) || (!l && is && br && m_inv.size() > 1);
    chk(tag, "active", active, e_act);
    chk(tag, "slot_cond", slot_cond, e_cond);
    chk(tag, "exec_ok", exec_ok, e_ok);
    chk(tag, "fault", fault, e_fault);
    chk(tag, "save_state", save_state, ref_word());
    @(posedge clk);
    if (rs) begin
      m_inv.delete();
      if (rw[3:0] != 0) begin
        int p = 0;
        while (!rw[p]) p++;
        m_base = rw[8:5];
        for (int i = 4; i > p; i--) m_inv.push_back(rw[i]);
      end else m_base = 0;
    end else if (l) begin
      if (!e_act && lm != 0) begin
        int p = 0;
        while (!lm[p]) p++;
        m_base = lc;
        m_inv.push_back(1'b0);
        for (int i = 3; i > p; i--) m_inv.push_back(lm[i]);
      end
    end else if (is && e_act) begin
      if (br && m_inv.size() > 1) m_inv.delete();
      else void'(m_inv.pop_front());
      if (m_inv.size() == 0) m_base = 0;
    end
  endtask

  task automatic ld(input logic [3:0] c, input logic [3:0] m, input string tag);
    step(1, c, m, 0, 0, 4'd0, 0, 9'd0, tag);
  endtask
  task automatic go(input logic [3:0] f, input string tag);
    step(0, 0, 0, 1, 0, f, 0, 9'd0, tag);
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [8:0] saved;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    step(0, 0, 0, 0, 0, 4'd0, 0, 9'd0, "R1");
    go(4'hF, "R6");
    for (int c = 0; c < 15; c++)
      for (int f = 0; f < 16; f++) begin
        ld(c[3:0], 4'b1000, "R2");
        go(f[3:0], "R5");
        step(0, 0, 0, 0, 0, 4'd0, 0, 9'd0, "R6");
      end
    ld(4'd0, 4'b0001, "R3");
    go(4'b0100, "R3"); go(4'b0000, "R3"); go(4'b0100, "R4"); go(4'b0000, "R6");
    go(4'b0000, "R6");
    ld(4'd10, 4'b1010, "R3");
    go(4'b1001, "R4"); go(4'b1001, "R4"); go(4'b0000, "R4");
    ld(4'd8, 4'b0100, "R3");
    go(4'b0010, "R4"); go(4'b0010, "R4");
    ld(4'd2, 4'b0000, "R10");
    go(4'b0010, "R10");
    ld(4'd4, 4'b0110, "R2");
    ld(4'd1, 4'b1000, "R9");
    step(1, 4'd3, 4'b1000, 1, 0, 4'd0, 0, 9'd0, "R12");
    go(4'b1000, "R9");
    step(0, 0, 0, 1, 1, 4'd0, 0, 9'd0, "R11");
    go(4'd0, "R11");
    ld(4'd6, 4'b1100, "R11");
    go(4'd1, "R11");
    step(0, 0, 0, 1, 1, 4'd1, 0, 9'd0, "R11");
    ld(4'd12, 4'b1011, "R7");
    go(4'd0, "R7");
    saved = ref_word();
    step(0, 0, 0, 1, 1, 4'd0, 0, 9'd0, "R11");
    ld(4'd3, 4'b1000, "R7");
    step(0, 0, 0, 1, 0, 4'd0, 1, saved, "R8");
    go(4'b0100, "R8"); go(4'b0000, "R8"); go(4'b0100, "R8"); go(4'b0, "R8");
    ld(4'd5, 4'b0100, "R8");
    step(1, 4'd9, 4'b1000, 1, 1, 4'd0, 1, 9'b1110_00000, "R8");
    go(4'd0, "R8");
    step(0, 0, 0, 0, 0, 4'd0, 1, 9'b0111_10010, "R8");
    go(4'd0, "R8"); go(4'd0, "R8"); go(4'd0, "R8");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule